// File: doc/BRIEF.md
# Host-Driven Memory Transfer Bridge

This block lets a host processor move data to and from an internal 32-bit memory bus through a small register window. The host fills a write staging buffer, programs a word count and then writes a target bus address. That address write is the start command, so no separate go bit is needed. A master sequencer then issues the words on the memory bus one beat at a time. The host polls a status bit until the transfer is done. For reads, it collects the returned words from a read staging buffer.

Host accesses are single-cycle requests on a plain register port. Read data appears on `host_rdata` one clock after the request. The memory side is a valid/ready master. The bridge raises `m_valid` with a stable address, direction and write data. A beat completes on every cycle in which `m_ready` is also high. A low `m_ready` back-pressures the bridge, which then holds the beat unchanged. Read data is taken from `m_rdata` in the same cycle the beat completes. A version register advertises the largest burst the bridge can issue. The host divides it by 16 to learn the burst limit.

Top module: `hbridge_top`

## Requirements
- R1: After synchronous reset the status register (word offset 0) reads 1: bit 0 (idle) is 1 and bit 1 (overrun) is 0. `m_valid` is also low.
- R2: The version register at word offset 3 reads MAX_BURST·16 + VERSION_ID, where VERSION_ID occupies bits 3:0. With the defaults this is 0x101.
- R3: A write to the size register (word offset 2) stores min(value, MAX_BURST), and that stored value is what reads back.
- R4: When idle, a host write to the write-address register (word offset 8) starts a bus write of size words, or one word if size is 0. Beat i carries address start+4·i and the write-buffer word i (host word offset 0xC0+i). No other beats occur.
- R5: When idle, a host write to the read-address register (word offset 4) starts a bus read of the same word count. Beat i uses address start+4·i, and its returned word becomes readable at host word offset 0x80+i.
- R6: Status bit 0 reads 0 from the cycle after a start is accepted until the last beat completes, and reads 1 afterwards.
- R7: While `m_valid` is high and `m_ready` is low, the address and direction stay unchanged. The bridge moves to the next word only on a cycle with both signals high.
- R8: A write to either address register while a transfer is in progress starts nothing and sets the sticky status bit 1. Writing 1 to bit 0 of the control register (word offset 1) clears that bit.
- R9: Host writes into the read-buffer window (word offsets 0x80 to 0xBF) have no effect on its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 8 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read request |
| m_valid | output | 1 | Memory beat valid |
| m_write | output | 1 | 1 = write beat, 0 = read beat |
| m_addr | output | 32 | Byte address of the current beat |
| m_wdata | output | 32 | Write data of the current beat |
| m_ready | input | 1 | Memory accepts or completes the beat |
| m_rdata | input | 32 | Read data, sampled on the completing cycle |

## Verification
The bench covers several transfer shapes: a size of 0, which must give exactly one beat rather than none; a full burst of MAX_BURST words; and an oversized size value. A design that got any of these wrong would issue the wrong number of beats, and the scoreboard would flag the missing or extra beats. Random back-pressure on `m_ready` exposes a sequencer that advances on a stalled cycle, which would show up as skipped or repeated addresses. A start command is also sent while a transfer is held off. A design that accepted it would emit unexpected read beats, and one without the sticky flag would report a clean status. A write into the read buffer is read back to catch a decoder that lets the host corrupt returned data.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HOST_AW  = 8;
  // host word offsets
  localparam int OFS_STAT  = 'h00;
  localparam int OFS_CTRL  = 'h01;
  localparam int OFS_SIZE  = 'h02;
  localparam int OFS_VER   = 'h03;
  localparam int OFS_RADDR = 'h04;
  localparam int OFS_WADDR = 'h08;
  localparam int OFS_RBUF  = 'h80;
  localparam int OFS_WBUF  = 'hC0;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/hb_buffer.sv
module hb_buffer #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int NRD   = 1,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][IW-1:0]  rd_idx,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_idx[g]];
  end
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 6,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  xfer_dir_e     start_dir,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_cnt,
  output logic          idle,
  output logic [IW-1:0] buf_idx,
  input  logic [DW-1:0] buf_wdata,
  output logic          rb_we,
  output logic [DW-1:0] rb_wdata,
  output logic          m_valid,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ready,
  input  logic [DW-1:0] m_rdata
);
  logic          busy_q;
  xfer_dir_e     dir_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] idx_q, last_q;
  logic          beat;

  assign beat = busy_q && m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_RD;
      addr_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        dir_q  <= start_dir;
        addr_q <= start_addr;
        idx_q  <= '0;
        last_q <= start_cnt - CW'(1);
      end
    end else if (beat) begin
      if (idx_q == last_q) begin
        busy_q <= 1'b0;
      end else begin
        idx_q  <= idx_q + CW'(1);
        addr_q <= addr_q + AW'(4);
      end
    end
  end

  assign idle     = !busy_q;
  assign m_valid  = busy_q;
  assign m_write  = (dir_q == DIR_WR);
  assign m_addr   = addr_q;
  assign m_wdata  = buf_wdata;
  assign buf_idx  = IW'(idx_q);
  assign rb_we    = beat && (dir_q == DIR_RD);
  assign rb_wdata = m_rdata;

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_valid) ##1 m_valid && !$rose(m_valid) |-> m_addr == $past(m_addr) + AW'(4));

  // R6
  idle_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> $past(m_valid && m_ready));
endmodule

// File: rtl/hb_regs.sv
module hb_regs
  import hb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int DEPTH      = 64,
  parameter int IW         = 6,
  parameter int CW         = 5,
  parameter int MAX_BURST  = 16,
  parameter int VERSION_ID = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  input  logic               seq_idle,
  output logic               start,
  output xfer_dir_e          start_dir,
  output logic [AW-1:0]      start_addr,
  output logic [CW-1:0]      start_cnt,
  output logic               wb_we,
  output logic [IW-1:0]      wb_idx,
  input  logic [DW-1:0]      wb_rdata,
  output logic [IW-1:0]      rb_idx,
  input  logic [DW-1:0]      rb_rdata
);
  localparam logic [DW-1:0] VER_WORD = (DW'(MAX_BURST) << 4) | DW'(VERSION_ID & 15);

  logic          in_rbuf, in_wbuf, wr_cyc, rd_cyc, start_req;
  logic [CW-1:0] size_q;
  logic [AW-1:0] last_addr_q;
  logic          overrun_q;
  logic [DW-1:0] rd_mux;

  assign wr_cyc  = host_req && host_wr;
  assign rd_cyc  = host_req && !host_wr;
  assign in_rbuf = (int'(host_addr) >= OFS_RBUF) && (int'(host_addr) < OFS_RBUF + DEPTH);
  assign in_wbuf = (int'(host_addr) >= OFS_WBUF) && (int'(host_addr) < OFS_WBUF + DEPTH);
  assign rb_idx  = IW'(host_addr - HOST_AW'(OFS_RBUF));
  assign wb_idx  = IW'(host_addr - HOST_AW'(OFS_WBUF));
  assign wb_we   = wr_cyc && in_wbuf;

  assign start_req  = wr_cyc && (host_addr == HOST_AW'(OFS_RADDR) ||
                                 host_addr == HOST_AW'(OFS_WADDR));
  assign start      = start_req && seq_idle;
  assign start_dir  = (host_addr == HOST_AW'(OFS_WADDR)) ? DIR_WR : DIR_RD;
  assign start_addr = AW'(host_wdata);
  assign start_cnt  = (size_q == '0) ? CW'(1) : size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q      <= '0;
      last_addr_q <= '0;
      overrun_q   <= 1'b0;
    end else begin
      if (wr_cyc && host_addr == HOST_AW'(OFS_SIZE))
        size_q <= (host_wdata > DW'(MAX_BURST)) ? CW'(MAX_BURST) : CW'(host_wdata);
      if (start) last_addr_q <= start_addr;
      if (start_req && !seq_idle)
        overrun_q <= 1'b1;
      else if (wr_cyc && host_addr == HOST_AW'(OFS_CTRL) && host_wdata[0])
        overrun_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_rbuf)                                  rd_mux = rb_rdata;
    else if (in_wbuf)                             rd_mux = wb_rdata;
    else if (host_addr == HOST_AW'(OFS_STAT))     rd_mux = DW'({overrun_q, seq_idle});
    else if (host_addr == HOST_AW'(OFS_SIZE))     rd_mux = DW'(size_q);
    else if (host_addr == HOST_AW'(OFS_VER))      rd_mux = VER_WORD;
    else if (host_addr == HOST_AW'(OFS_RADDR) ||
             host_addr == HOST_AW'(OFS_WADDR))    rd_mux = DW'(last_addr_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         host_rdata <= '0;
    else if (rd_cyc) host_rdata <= rd_mux;
  end

  // R3
  size_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    int'(size_q) <= MAX_BURST);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (start_req && !seq_idle) |=> overrun_q);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !seq_idle);

  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !seq_idle |-> !start);
endmodule

// File: rtl/hbridge_top.sv
module hbridge_top
  import hb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BUF_DEPTH  = 64,
  parameter int MAX_BURST  = 16,
  parameter int VERSION_ID = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               m_valid,
  output logic               m_write,
  output logic [ADDR_W-1:0]  m_addr,
  output logic [DATA_W-1:0]  m_wdata,
  input  logic               m_ready,
  input  logic [DATA_W-1:0]  m_rdata
);
  localparam int IW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(MAX_BURST + 1);

  logic                        seq_idle, start;
  xfer_dir_e                   start_dir;
  logic [ADDR_W-1:0]           start_addr;
  logic [CW-1:0]               start_cnt;
  logic                        wb_we, rb_we;
  logic [IW-1:0]               wb_idx, rb_host_idx, seq_idx;
  logic [DATA_W-1:0]           rb_wdata;
  logic [1:0][IW-1:0]          wb_rd_idx;
  logic [1:0][DATA_W-1:0]      wb_rd_data;
  logic [0:0][IW-1:0]          rb_rd_idx;
  logic [0:0][DATA_W-1:0]      rb_rd_data;

  assign wb_rd_idx = {seq_idx, wb_idx};
  assign rb_rd_idx = rb_host_idx;

  hb_regs #(
    .AW(ADDR_W), .DW(DATA_W), .DEPTH(BUF_DEPTH), .IW(IW), .CW(CW),
    .MAX_BURST(MAX_BURST), .VERSION_ID(VERSION_ID)
  ) u_regs (
    .clk, .rst, .host_req, .host_wr, .host_addr, .host_wdata, .host_rdata,
    .seq_idle, .start, .start_dir, .start_addr, .start_cnt,
    .wb_we, .wb_idx, .wb_rdata(wb_rd_data[0]),
    .rb_idx(rb_host_idx), .rb_rdata(rb_rd_data[0])
  );

  hb_buffer #(.DEPTH(BUF_DEPTH), .DW(DATA_W), .NRD(2), .IW(IW)) u_wbuf (
    .clk, .wr_en(wb_we), .wr_idx(wb_idx), .wr_data(host_wdata),
    .rd_idx(wb_rd_idx), .rd_data(wb_rd_data)
  );

  hb_buffer #(.DEPTH(BUF_DEPTH), .DW(DATA_W), .NRD(1), .IW(IW)) u_rbuf (
    .clk, .wr_en(rb_we), .wr_idx(seq_idx), .wr_data(rb_wdata),
    .rd_idx(rb_rd_idx), .rd_data(rb_rd_data)
  );

  hb_seq #(.AW(ADDR_W), .DW(DATA_W), .IW(IW), .CW(CW)) u_seq (
    .clk, .rst, .start, .start_dir, .start_addr, .start_cnt,
    .idle(seq_idle), .buf_idx(seq_idx), .buf_wdata(wb_rd_data[1]),
    .rb_we, .rb_wdata, .m_valid, .m_write, .m_addr, .m_wdata,
    .m_ready, .m_rdata
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!m_valid && seq_idle));
endmodule

// File: tb/hbridge_top_tb.sv
module hbridge_top_tb_top;
  localparam int MB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        m_valid, m_write, m_ready = 1'b1;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;

  always #2.5 clk = ~clk;

  hbridge_top dut_i (
    .clk, .rst, .host_req, .host_wr, .host_addr, .host_wdata, .host_rdata,
    .m_valid, .m_write, .m_addr, .m_wdata, .m_ready, .m_rdata
  );

  int checks = 0, errors = 0;
  typedef struct packed { logic w; logic [31:0] a; logic [31:0] d; } beat_t;
  beat_t exp_q[$];
  logic [31:0] model [logic [31:0]];
  logic stall_en = 1'b0, hold_off = 1'b0;
  logic [3:0] lfsr = 4'h9;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  always @(negedge clk) begin
    beat_t e;
    lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    m_ready = hold_off ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
    m_rdata = model.exists(m_addr) ? model[m_addr] : 32'h0;
    if (!rst && m_valid && m_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: actual beat at %h expected no beat", m_addr);
      end else begin
        e = exp_q.pop_front();
        if (e.w !== m_write || e.a !== m_addr || (e.w && e.d !== m_wdata)) begin
          errors++;
          $display("FAIL R4/R5: actual w=%0b a=%h d=%h expected w=%0b a=%h d=%h",
                   m_write, m_addr, m_wdata, e.w, e.a, e.d);
        end
        if (m_write) model[m_addr] = m_wdata;
      end
    end
  end

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    d = host_rdata;
  endtask

  task automatic poll_idle();
    logic [31:0] s;
    for (int k = 0; k < 2000; k++) begin
      hread(8'h00, s);
      if (s[0]) return;
    end
    errors++; checks++;
    $display("FAIL R6: actual busy expected idle");
  endtask

  function automatic int nbeats(input int sz);
    return (sz == 0) ? 1 : ((sz > MB) ? MB : sz);
  endfunction

  task automatic do_write(input logic [31:0] base, input int sz, input logic [31:0] seed);
    int n = nbeats(sz);
    for (int i = 0; i < n; i++) hwrite(8'hC0 + 8'(i), seed + 32'(i) * 32'h01010101);
    hwrite(8'h02, 32'(sz));
    for (int i = 0; i < n; i++)
      exp_q.push_back('{1'b1, base + 32'(4 * i), seed + 32'(i) * 32'h01010101});
    hwrite(8'h08, base);
    poll_idle();
  endtask

  task automatic do_read(input logic [31:0] base, input int sz);
    logic [31:0] d;
    int n = nbeats(sz);
    hwrite(8'h02, 32'(sz));
    for (int i = 0; i < n; i++) exp_q.push_back('{1'b0, base + 32'(4 * i), 32'h0});
    hwrite(8'h04, base);
    poll_idle();
    for (int i = 0; i < n; i++) begin
      hread(8'h80 + 8'(i), d);
      chk("R5 read buffer word", d, model.exists(base + 32'(4 * i)) ? model[base + 32'(4 * i)] : 32'h0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 m_valid", 32'(m_valid), 32'h0);
    hread(8'h00, d); chk("R1 status", d, 32'h1);
    hread(8'h03, d); chk("R2 version", d, 32'h101);
    hwrite(8'h02, 32'd40); hread(8'h02, d); chk("R3 clamp", d, 32'd16);
    hwrite(8'h02, 32'd3);  hread(8'h02, d); chk("R3 plain", d, 32'd3);

    // burst with back-pressure (R4, R5, R7)
    stall_en = 1'b1;
    do_write(32'h4000_0000, 4, 32'h1000_0000);
    do_read(32'h4000_0000, 4);
    // size 0 is one word
    do_write(32'h6000_0000, 0, 32'hABCD_0001);
    do_read(32'h6000_0000, 0);
    // full burst and oversized size
    do_write(32'hA000_0000, MB, 32'h5500_0000);
    do_read(32'hA000_0000, 100);
    stall_en = 1'b0;
    do_write(32'h7000_0000, 2, 32'h1234_5678);
    do_read(32'h7000_0000, 2);

    // busy status and overrun (R6, R7, R8)
    hold_off = 1'b1;
    for (int i = 0; i < 2; i++) hwrite(8'hC0 + 8'(i), 32'hF0F0_0000 + 32'(i));
    hwrite(8'h02, 32'd2);
    for (int i = 0; i < 2; i++)
      exp_q.push_back('{1'b1, 32'h2000_0000 + 32'(4 * i), 32'hF0F0_0000 + 32'(i)});
    hwrite(8'h08, 32'h2000_0000);
    hread(8'h00, d); chk("R6 busy status", d, 32'h0);
    chk("R7 held address", m_addr, 32'h2000_0000);
    hwrite(8'h04, 32'h3000_0000);
    hread(8'h00, d); chk("R8 overrun set", d, 32'h2);
    chk("R7 held valid", 32'(m_valid), 32'h1);
    chk("R7 held address after stall", m_addr, 32'h2000_0000);
    hold_off = 1'b0;
    poll_idle();
    hread(8'h00, d); chk("R8 overrun sticky", d, 32'h3);
    hwrite(8'h01, 32'h1);
    hread(8'h00, d); chk("R8 overrun cleared", d, 32'h1);

    // read buffer is host read-only (R9)
    hwrite(8'h80, 32'hDEAD_BEEF);
    hread(8'h80, d); chk("R9 rbuf write ignored", d, model[32'h7000_0000]);

    repeat (4) @(negedge clk);
    chk("R4 all beats seen", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule